// File: doc/BRIEF.md
# Priority-Based Reference Clock Selector

This block picks one of five reference clock candidates for each of two timing paths, a main path and an auxiliary path. Candidates are numbered 1 to 5. Numbers 1 to 3 are the single-ended inputs and numbers 4 and 5 are the differential inputs. Each path has a 4-bit mode field. That field either forces a fixed candidate or lets the block choose on its own. When the block chooses, it takes the best-priority candidate among those whose validity bit is set.

Software programs the block through a small write-only register port. The selection field and the five priority fields exist once per path, but they share one set of addresses. A target bit decides which path a write to those addresses reaches. Quality monitoring happens outside the block and arrives as a validity vector. Each path drives a registered index, a "no reference" flag and a one-cycle switch strobe. All the pins are plain control and status pins. There is no streaming interface, so no back-pressure rules apply.

Top module: `refsel_top`

## Requirements
- R1: While reset is held, both paths output index 0, "no reference" low and switch strobe low. Reset also leaves both mode fields at 0 and sets priority field k of both paths to k. The target bit resets to 0 (main).
- R2: When a path's mode field holds 1 to 5, that path outputs that index and holds "no reference" low. The validity vector has no effect in this case.
- R3: In automatic mode a path selects the valid candidate with the smallest non-zero priority value. Bit k-1 of `ref_valid` marks candidate k valid.
- R4: In automatic mode, when two or more valid candidates tie on priority, the one with the lowest index wins.
- R5: A priority value of 0 excludes that candidate from automatic selection, even if it is valid.
- R6: In automatic mode with no valid candidate of non-zero priority, the path keeps its previous index and raises "no reference".
- R7: A mode field value of 0, or any value from 6 to 15, selects automatic mode.
- R8: The write port uses these addresses:
  - Address 0, bit 0: target bit (0 = main, 1 = auxiliary).
  - Address 1, bits 3:0: mode field.
  - Address 1+k, bits 3:0: priority of candidate k.
  Writes to addresses 1 to 6 reach only the targeted path, and the other path's outputs are unchanged.
- R9: A path's switch strobe is high for exactly the one cycle in which its output index first shows a new value.
- R10: A register write at a clock edge affects the outputs at the following edge. A change of `ref_valid` affects the outputs at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| ref_valid | input | 5 | Per-candidate validity, bit k-1 for candidate k |
| main_sel | output | 3 | Main path selected index (0 = none yet) |
| main_none | output | 1 | Main path has no usable candidate |
| main_sw | output | 1 | Main path selection changed this cycle |
| aux_sel | output | 3 | Auxiliary path selected index |
| aux_none | output | 1 | Auxiliary path has no usable candidate |
| aux_sw | output | 1 | Auxiliary path selection changed this cycle |

## Verification
A register write and a validity change can land on the same clock edge, and each one moves the selection along its own pipeline depth. The bench provokes this by switching the main path from forced to automatic mode in the same cycle that it drops the validity of one candidate. The checks then confirm that the first edge reflects only the new validity under the old forced mode. They also confirm that the second edge settles on the automatic winner with a single switch strobe. The auxiliary path is checked at the same time to show it stays untouched.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
  localparam int unsigned NUM_IN  = 5;
  localparam int unsigned PRIO_W  = 4;
  localparam int unsigned FIELD_W = 4;
  localparam int unsigned ADDR_W  = 3;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned NUM_PATH = 2;

  typedef enum logic {
    PATH_MAIN = 1'b0,
    PATH_AUX  = 1'b1
  } path_e;
endpackage

// File: rtl/refsel_cfg.sv
module refsel_cfg #(
  parameter int unsigned N  = refsel_pkg::NUM_IN,
  parameter int unsigned PW = refsel_pkg::PRIO_W,
  parameter int unsigned FW = refsel_pkg::FIELD_W,
  parameter int unsigned AW = refsel_pkg::ADDR_W,
  parameter int unsigned DW = refsel_pkg::DATA_W,
  parameter int unsigned NP = refsel_pkg::NUM_PATH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic [DW-1:0]       wdata,
  output logic [NP*FW-1:0]    mode_q,
  output logic [NP*N*PW-1:0]  prio_q
);
  localparam int unsigned PRIO_BASE = 2;

  refsel_pkg::path_e target_q;

  always_ff @(posedge clk) begin
    if (!rst_n)
      target_q <= refsel_pkg::PATH_MAIN;
    else if (we && addr == AW'(0))
      target_q <= refsel_pkg::path_e'(wdata[0]);
  end

  for (genvar p = 0; p < NP; p++) begin : g_path
    logic hit;
    assign hit = we && (int'(target_q) == p);

    always_ff @(posedge clk) begin
      if (!rst_n)
        mode_q[p*FW +: FW] <= '0;
      else if (hit && addr == AW'(1))
        mode_q[p*FW +: FW] <= wdata[FW-1:0];
    end

    for (genvar k = 0; k < N; k++) begin : g_prio
      always_ff @(posedge clk) begin
        if (!rst_n)
          prio_q[(p*N+k)*PW +: PW] <= PW'(k + 1);
        else if (hit && addr == AW'(PRIO_BASE + k))
          prio_q[(p*N+k)*PW +: PW] <= wdata[PW-1:0];
      end
    end
  end
endmodule

// File: rtl/refsel_pick.sv
module refsel_pick #(
  parameter int unsigned N  = refsel_pkg::NUM_IN,
  parameter int unsigned PW = refsel_pkg::PRIO_W,
  parameter int unsigned IW = $clog2(N + 1)
) (
  input  logic [N-1:0]    valid,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IW-1:0]   idx
);
  logic [PW-1:0] best;
  logic [PW-1:0] cur;

  // Strict less-than while scanning upward keeps the lowest index on ties.
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '0;
    cur   = '0;
    for (int i = 0; i < N; i++) begin
      cur = prio[i*PW +: PW];
      if (valid[i] && cur != '0 && (!found || cur < best)) begin
        found = 1'b1;
        best  = cur;
        idx   = IW'(i + 1);
      end
    end
  end
endmodule

// File: rtl/refsel_path.sv
module refsel_path #(
  parameter int unsigned N  = refsel_pkg::NUM_IN,
  parameter int unsigned PW = refsel_pkg::PRIO_W,
  parameter int unsigned FW = refsel_pkg::FIELD_W,
  parameter int unsigned IW = $clog2(N + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [FW-1:0]   mode,
  input  logic [N-1:0]    valid,
  input  logic [N*PW-1:0] prio,
  output logic [IW-1:0]   sel,
  output logic            none,
  output logic            sw
);
  logic          found;
  logic [IW-1:0] win;
  logic          forced;
  logic [IW-1:0] sel_d;

  refsel_pick #(.N(N), .PW(PW), .IW(IW)) u_pick (
    .valid (valid),
    .prio  (prio),
    .found (found),
    .idx   (win)
  );

  assign forced = (mode != '0) && (mode <= FW'(N));

  always_comb begin
    if (forced)     sel_d = IW'(mode);
    else if (found) sel_d = win;
    else            sel_d = sel;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel  <= '0;
      none <= 1'b0;
      sw   <= 1'b0;
    end else begin
      sel  <= sel_d;
      none <= !forced && !found;
      sw   <= (sel_d != sel);
    end
  end
endmodule

// File: rtl/refsel_top.sv
module refsel_top #(
  parameter int unsigned N  = refsel_pkg::NUM_IN,
  parameter int unsigned PW = refsel_pkg::PRIO_W,
  parameter int unsigned FW = refsel_pkg::FIELD_W,
  parameter int unsigned AW = refsel_pkg::ADDR_W,
  parameter int unsigned DW = refsel_pkg::DATA_W,
  localparam int unsigned IW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  input  logic [N-1:0]  ref_valid,
  output logic [IW-1:0] main_sel,
  output logic          main_none,
  output logic          main_sw,
  output logic [IW-1:0] aux_sel,
  output logic          aux_none,
  output logic          aux_sw
);
  localparam int unsigned NP = refsel_pkg::NUM_PATH;

  logic [NP*FW-1:0]   mode_q;
  logic [NP*N*PW-1:0] prio_q;
  logic [IW-1:0]      sel_v  [NP];
  logic               none_v [NP];
  logic               sw_v   [NP];
  logic [FW-1:0]      main_mode;
  logic [FW-1:0]      aux_mode;

  refsel_cfg #(.N(N), .PW(PW), .FW(FW), .AW(AW), .DW(DW), .NP(NP)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .mode_q (mode_q),
    .prio_q (prio_q)
  );

  for (genvar p = 0; p < NP; p++) begin : g_path
    refsel_path #(.N(N), .PW(PW), .FW(FW), .IW(IW)) u_path (
      .clk   (clk),
      .rst_n (rst_n),
      .mode  (mode_q[p*FW +: FW]),
      .valid (ref_valid),
      .prio  (prio_q[p*N*PW +: N*PW]),
      .sel   (sel_v[p]),
      .none  (none_v[p]),
      .sw    (sw_v[p])
    );
  end

  assign main_mode = mode_q[0 +: FW];
  assign aux_mode  = mode_q[FW +: FW];

  assign main_sel  = sel_v[0];
  assign main_none = none_v[0];
  assign main_sw   = sw_v[0];
  assign aux_sel   = sel_v[1];
  assign aux_none  = none_v[1];
  assign aux_sw    = sw_v[1];
endmodule

// File: rtl/refsel_checker.sv
module refsel_checker #(
  parameter int unsigned N  = refsel_pkg::NUM_IN,
  parameter int unsigned FW = refsel_pkg::FIELD_W,
  parameter int unsigned IW = $clog2(N + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  ref_valid,
  input logic [FW-1:0] main_mode,
  input logic [FW-1:0] aux_mode,
  input logic [IW-1:0] main_sel,
  input logic          main_none,
  input logic          main_sw,
  input logic [IW-1:0] aux_sel,
  input logic          aux_none,
  input logic          aux_sw
);
  logic main_forced;
  logic aux_forced;
  logic [N:0] valid_q;
  logic main_auto_q;

  assign main_forced = (main_mode != '0) && (main_mode <= FW'(N));
  assign aux_forced  = (aux_mode != '0) && (aux_mode <= FW'(N));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q     <= '0;
      main_auto_q <= 1'b0;
    end else begin
      valid_q     <= {ref_valid, 1'b0};
      main_auto_q <= !main_forced;
    end
  end

  p_forced_main_r2: assert property (@(posedge clk) disable iff (!rst_n)
    main_forced |=> (main_sel == IW'($past(main_mode)) && !main_none));
  p_forced_aux_r2: assert property (@(posedge clk) disable iff (!rst_n)
    aux_forced |=> (aux_sel == IW'($past(aux_mode)) && !aux_none));
  p_auto_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (main_auto_q && !main_none && main_sel != '0) |-> valid_q[main_sel]);
  p_hold_main_r6: assert property (@(posedge clk) disable iff (!rst_n)
    main_none |-> (main_sel == $past(main_sel)));
  p_hold_aux_r6: assert property (@(posedge clk) disable iff (!rst_n)
    aux_none |-> (aux_sel == $past(aux_sel)));
  p_sw_main_r9: assert property (@(posedge clk) disable iff (!rst_n)
    main_sw == (main_sel != $past(main_sel)));
  p_sw_aux_r9: assert property (@(posedge clk) disable iff (!rst_n)
    aux_sw == (aux_sel != $past(aux_sel)));
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (main_sel <= IW'(N)) && (aux_sel <= IW'(N)));
endmodule

bind refsel_top refsel_checker #(.N(N), .FW(FW), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ref_valid (ref_valid),
  .main_mode (main_mode),
  .aux_mode  (aux_mode),
  .main_sel  (main_sel),
  .main_none (main_none),
  .main_sw   (main_sw),
  .aux_sel   (aux_sel),
  .aux_none  (aux_none),
  .aux_sw    (aux_sw)
);

// File: tb/refsel_top_bench.sv
`timescale 1ns/1ps
module refsel_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [4:0] ref_valid = '0;
  logic [2:0] main_sel, aux_sel;
  logic       main_none, main_sw, aux_none, aux_sw;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  refsel_top u_refsel_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ref_valid(ref_valid),
    .main_sel(main_sel), .main_none(main_none), .main_sw(main_sw),
    .aux_sel(aux_sel), .aux_none(aux_none), .aux_sw(aux_sw)
  );

  // {we, addr, data, valid, main_sel, main_none, aux_sel, aux_none}
  localparam int NV = 16;
  localparam logic [24:0] VEC [NV] = '{
    {1'b0, 3'd0, 8'd0,  5'b11111, 3'd1, 1'b0, 3'd1, 1'b0}, // R3
    {1'b0, 3'd0, 8'd0,  5'b11110, 3'd2, 1'b0, 3'd2, 1'b0}, // R3
    {1'b1, 3'd6, 8'd1,  5'b11110, 3'd5, 1'b0, 3'd2, 1'b0}, // R3 R8
    {1'b1, 3'd3, 8'd1,  5'b11110, 3'd2, 1'b0, 3'd2, 1'b0}, // R4
    {1'b1, 3'd3, 8'd0,  5'b11110, 3'd5, 1'b0, 3'd2, 1'b0}, // R5
    {1'b0, 3'd0, 8'd0,  5'b00010, 3'd5, 1'b1, 3'd2, 1'b0}, // R5 R6
    {1'b0, 3'd0, 8'd0,  5'b00000, 3'd5, 1'b1, 3'd2, 1'b1}, // R6
    {1'b1, 3'd1, 8'd3,  5'b00000, 3'd3, 1'b0, 3'd2, 1'b1}, // R2
    {1'b1, 3'd0, 8'd1,  5'b00000, 3'd3, 1'b0, 3'd2, 1'b1}, // R8
    {1'b1, 3'd1, 8'd4,  5'b00000, 3'd3, 1'b0, 3'd4, 1'b0}, // R8 R2
    {1'b1, 3'd2, 8'd7,  5'b11111, 3'd3, 1'b0, 3'd4, 1'b0}, // R2
    {1'b1, 3'd1, 8'd9,  5'b11111, 3'd3, 1'b0, 3'd2, 1'b0}, // R7
    {1'b1, 3'd0, 8'd0,  5'b11111, 3'd3, 1'b0, 3'd2, 1'b0}, // R8
    {1'b1, 3'd1, 8'd15, 5'b11111, 3'd1, 1'b0, 3'd2, 1'b0}, // R7 R4
    {1'b1, 3'd1, 8'd5,  5'b00000, 3'd5, 1'b0, 3'd2, 1'b1}, // R2
    {1'b1, 3'd1, 8'd6,  5'b00000, 3'd5, 1'b1, 3'd2, 1'b1}  // R7 R6
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] act8, exp8;
    // R1: reset state
    repeat (3) @(negedge clk);
    check({main_sel, main_none, main_sw, aux_sel, aux_none, aux_sw} == 10'b0,
          "R1", {main_sel, main_none, main_sw, aux_sel, aux_none, aux_sw}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(main_sel == 0 && main_none && aux_sel == 0 && aux_none,
          "R1 R6", {main_sel, main_none, aux_sel, aux_none}, 8'b0001_0001);

    // Vector table
    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      cfg_we    = VEC[v][24];
      cfg_addr  = VEC[v][23:21];
      cfg_wdata = VEC[v][20:13];
      ref_valid = VEC[v][12:8];
      @(negedge clk);
      cfg_we = 1'b0;
      @(negedge clk);
      act8 = {main_sel, main_none, aux_sel, aux_none};
      exp8 = VEC[v][7:0];
      check(act8 == exp8, $sformatf("R2-table vec%0d", v), act8, exp8);
    end

    // R9: switch strobe on main only, one cycle
    @(negedge clk);
    ref_valid = 5'b11111;
    @(negedge clk);
    check(main_sel == 1 && main_sw && !aux_sw, "R9", {main_sel, main_sw, aux_sw}, 5'b00110);
    @(negedge clk);
    check(!main_sw && main_sel == 1, "R9", {main_sel, main_sw}, 4'b0010);

    // R10: write takes effect one edge later
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 8'd4;
    @(negedge clk);
    cfg_we = 1'b0;
    check(main_sel == 1 && !main_sw, "R10", main_sel, 1);
    @(negedge clk);
    check(main_sel == 4 && main_sw, "R10 R2", {main_sel, main_sw}, 4'b1001);

    // Coincident mode write and validity drop
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 3'd1; cfg_wdata = 8'd0; ref_valid = 5'b11110;
    @(negedge clk);
    cfg_we = 1'b0;
    check(main_sel == 4 && !main_sw, "R10 R2", {main_sel, main_sw}, 4'b1000);
    @(negedge clk);
    check(main_sel == 5 && main_sw && !main_none, "R10 R3", {main_sel, main_sw, main_none}, 5'b10110);
    check(aux_sel == 2 && !aux_sw && !aux_none, "R8", {aux_sel, aux_sw, aux_none}, 5'b01000);

    // R6 again via aux: drop all validity
    write_reg(3'd0, 8'd1);
    @(negedge clk);
    ref_valid = 5'b00000;
    @(negedge clk);
    check(aux_sel == 2 && aux_none && !aux_sw, "R6", {aux_sel, aux_none, aux_sw}, 5'b01010);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule